// File: doc/BRIEF.md
# Indirect Branch Target Table Walker

This block resolves the destination of an indirect branch. It searches a translation table that lives in memory. When a lookup starts, the block takes the branch's virtual address, the current address-space identifier, a table base and a contiguous index mask. From these it forms the address of one 8-way set. It then reads the set's 128-bit entries one at a time over a simple request/response memory port and checks each entry as it comes back.

The walk ends at the first entry that qualifies, and the block reports a hit with that entry's 32-bit target. If all eight entries fail, the block reports a table fault carrying trap number 16. Filling the table, translating the table's own address and delivering the trap are handled elsewhere. A front end starts a lookup with a single `start` pulse and waits for the `done` pulse.

Top module: `ibt_walker`

## Requirements
- R1: After reset, `busy`, `done`, `hit`, `fault` and `mem_req` are 0, and `target` and `fault_num` are zero.
- R2: The set address is (`base` OR ((`va` >> 4) AND `mask`)) with bits [6:0] forced to zero, computed on 52 bits.
- R3: Entries are requested in way order 0, 1, 2 and so on, way w at set address + 16*w. `mem_req` is a one-cycle pulse, and the next request is issued only after `mem_rvalid` has returned the previous entry.
- R4: An entry qualifies only when all of these hold: its bit 95 (enable) is 1, its bits [63:0] equal `va`, and its bits [87:64] equal `asid`.
- R5: An entry whose bits [94:88] are not all zero never qualifies, even when every other field matches.
- R6: The walk stops at the first qualifying way, so the lowest qualifying way wins. `hit` is then 1 and `target` shows that entry's bits [127:96]. No further reads follow.
- R7: When no way qualifies after 8 reads, `done` comes with `fault`=1, `hit`=0 and `fault_num`=16. `hit` and `fault` are never 1 together.
- R8: `busy` rises in the cycle after an accepted `start` and stays high through the one-cycle `done` pulse, then falls. A `start` while `busy` is high is ignored and changes neither the walk nor its result.
- R9: Outside the `done` cycle, `hit`, `fault`, `target` and `fault_num` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a lookup (taken only when idle) |
| va | input | 64 | Virtual branch address to look up |
| asid | input | 24 | Current address-space identifier |
| base | input | 52 | Table base address |
| mask | input | 52 | Contiguous low-order index mask |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Lookup found a qualifying entry (with done) |
| fault | output | 1 | Lookup found nothing (with done) |
| fault_num | output | 5 | Trap number, 16 on fault, else 0 |
| target | output | 32 | Target of the hitting entry |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 52 | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 128 | Returned table entry |

## Verification
The bench places a qualifying entry in each way in turn. It also builds sets where two ways qualify, so that a walker that kept searching, or that let a later way overwrite the result, would return the wrong target or issue too many reads. It plants near-miss entries that fail on a single field each: enable clear, non-zero reserved bits, an ASID off by one, an address differing in its top bit. A comparator that skipped any one of those fields would report a false hit. The bench sweeps the mask width over 21 settings with a fixed base and checks every request address, which exposes a wrong shift, a missing alignment or a mask applied to the base. A second start pulse in the middle of a walk would, if accepted, restart the read sequence and change the read count.

// File: rtl/ibt_pkg.sv
package ibt_pkg;
   localparam int IBT_VA_W      = 64;
   localparam int IBT_ASID_W    = 24;
   localparam int IBT_RSV_W     = 7;
   localparam int IBT_TGT_W     = 32;
   localparam int IBT_ENTRY_W   = IBT_VA_W + IBT_ASID_W + IBT_RSV_W + 1 + IBT_TGT_W;
   localparam int IBT_SLOT_LG   = 4;
   localparam int IBT_FAULT_W   = 5;
   localparam int IBT_FAULT_NUM = 16;

   typedef struct packed {
      logic [IBT_TGT_W-1:0]  tgt;
      logic                  en;
      logic [IBT_RSV_W-1:0]  rsv;
      logic [IBT_ASID_W-1:0] asid;
      logic [IBT_VA_W-1:0]   va;
   } ibt_entry_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2,
      ST_DONE = 2'd3
   } ibt_state_e;
endpackage

// File: rtl/ibt_set_addr.sv
module ibt_set_addr #(
   parameter int PA_W    = 52,
   parameter int WAYS    = 8,
   parameter int SLOT_LG = 4
) (
   input  logic [PA_W-1:0] va_idx,
   input  logic [PA_W-1:0] base,
   input  logic [PA_W-1:0] mask,
   output logic [PA_W-1:0] set_addr
);
   localparam int ALIGN_LG = $clog2(WAYS) + SLOT_LG;

   logic [PA_W-1:0] raw;

   always_comb begin
      raw      = base | (va_idx & mask);
      set_addr = {raw[PA_W-1:ALIGN_LG], {ALIGN_LG{1'b0}}};
   end
endmodule

// File: rtl/ibt_entry_cmp.sv
module ibt_entry_cmp
   import ibt_pkg::*;
(
   input  logic [IBT_ENTRY_W-1:0] entry,
   input  logic [IBT_VA_W-1:0]    va,
   input  logic [IBT_ASID_W-1:0]  asid,
   output logic                   match,
   output logic [IBT_TGT_W-1:0]   tgt
);
   ibt_entry_t e;

   always_comb begin
      e     = ibt_entry_t'(entry);
      match = e.en && (e.rsv == '0) && (e.va == va) && (e.asid == asid);
      tgt   = e.tgt;
   end
endmodule

// File: rtl/ibt_walk_ctrl.sv
module ibt_walk_ctrl
   import ibt_pkg::*;
#(
   parameter int WAYS  = 8,
   parameter int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             rvalid,
   input  logic             match,
   output logic             accept,
   output logic             take,
   output logic             busy,
   output logic             req,
   output logic             done,
   output logic             found,
   output logic [WAY_W-1:0] way
);
   localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

   ibt_state_e       state_q;
   logic [WAY_W-1:0] way_q;
   logic             found_q;

   always_comb begin
      accept = (state_q == ST_IDLE) && start;
      take   = (state_q == ST_WAIT) && rvalid && match;
      busy   = (state_q != ST_IDLE);
      req    = (state_q == ST_REQ);
      done   = (state_q == ST_DONE);
      found  = found_q;
      way    = way_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         way_q   <= '0;
         found_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start) begin
               state_q <= ST_REQ;
               way_q   <= '0;
               found_q <= 1'b0;
            end
            ST_REQ: state_q <= ST_WAIT;
            ST_WAIT: if (rvalid) begin
               if (match) begin
                  found_q <= 1'b1;
                  state_q <= ST_DONE;
               end else if (way_q == LAST_WAY) begin
                  state_q <= ST_DONE;
               end else begin
                  way_q   <= way_q + 1'b1;
                  state_q <= ST_REQ;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R8
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && start) |=> (state_q == ST_REQ && way_q == '0));
   // R3
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_REQ) |=> (state_q != ST_REQ));
   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DONE) |=> (state_q == ST_IDLE));
   // R6
   stop_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && rvalid && match) |=> (state_q == ST_DONE && found_q));
endmodule

// File: rtl/ibt_walker.sv
module ibt_walker
   import ibt_pkg::*;
#(
   parameter int PA_W = 52,
   parameter int WAYS = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [IBT_VA_W-1:0]    va,
   input  logic [IBT_ASID_W-1:0]  asid,
   input  logic [PA_W-1:0]        base,
   input  logic [PA_W-1:0]        mask,
   output logic                   busy,
   output logic                   done,
   output logic                   hit,
   output logic                   fault,
   output logic [IBT_FAULT_W-1:0] fault_num,
   output logic [IBT_TGT_W-1:0]   target,
   output logic                   mem_req,
   output logic [PA_W-1:0]        mem_addr,
   input  logic                   mem_rvalid,
   input  logic [IBT_ENTRY_W-1:0] mem_rdata
);
   localparam int WAY_W = $clog2(WAYS);

   generate
      if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
         $error("WAYS must be a power of two of at least 2");
      end
      if (PA_W + IBT_SLOT_LG > IBT_VA_W) begin : g_bad_pa
         $error("PA_W too wide for the virtual address");
      end
      if (IBT_ENTRY_W != 128) begin : g_bad_entry
         $error("entry layout must total 128 bits");
      end
   endgenerate

   logic [PA_W-1:0]       set_c, set_q;
   logic [IBT_VA_W-1:0]   va_q;
   logic [IBT_ASID_W-1:0] asid_q;
   logic [IBT_TGT_W-1:0]  tgt_c, tgt_q;
   logic                  match_c, accept, take, found;
   logic [WAY_W-1:0]      way;

   ibt_set_addr #(.PA_W(PA_W), .WAYS(WAYS), .SLOT_LG(IBT_SLOT_LG)) u_set (
      .va_idx   (va[PA_W+IBT_SLOT_LG-1:IBT_SLOT_LG]),
      .base     (base),
      .mask     (mask),
      .set_addr (set_c)
   );

   ibt_entry_cmp u_cmp (
      .entry (mem_rdata),
      .va    (va_q),
      .asid  (asid_q),
      .match (match_c),
      .tgt   (tgt_c)
   );

   ibt_walk_ctrl #(.WAYS(WAYS)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .rvalid (mem_rvalid),
      .match  (match_c),
      .accept (accept),
      .take   (take),
      .busy   (busy),
      .req    (mem_req),
      .done   (done),
      .found  (found),
      .way    (way)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         set_q  <= '0;
         va_q   <= '0;
         asid_q <= '0;
         tgt_q  <= '0;
      end else begin
         if (accept) begin
            set_q  <= set_c;
            va_q   <= va;
            asid_q <= asid;
         end
         if (take) tgt_q <= tgt_c;
      end
   end

   always_comb begin
      mem_addr  = mem_req ? (set_q | PA_W'({way, {IBT_SLOT_LG{1'b0}}})) : '0;
      hit       = done && found;
      fault     = done && !found;
      target    = hit ? tgt_q : '0;
      fault_num = fault ? IBT_FAULT_W'(IBT_FAULT_NUM) : '0;
   end

   // R9
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (!hit && !fault && target == '0 && fault_num == '0));
   // R7
   excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit && fault));
   // R2
   slot_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[IBT_SLOT_LG-1:0] == '0));
   // R3
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);
endmodule

// File: tb/test_ibt_walker.sv
`timescale 1ns/100ps
module test_ibt_walker;
   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [63:0]   va = '0;
   logic [23:0]   asid = '0;
   logic [51:0]   base = '0;
   logic [51:0]   mask = '0;
   logic          busy, done, hit, fault, mem_req;
   logic [4:0]    fault_num;
   logic [31:0]   target;
   logic [51:0]   mem_addr;
   logic          mem_rvalid = 1'b0;
   logic [127:0]  mem_rdata = '0;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [127:0] tbl [8];
   int           nreads = 0;
   int           rd_base = 0;
   logic [51:0]  exp_set = '0;
   bit           addr_bad = 0;
   int           lat = 0;
   logic [51:0]  paddr = '0;

   always #2.5 clk = ~clk;

   ibt_walker i_ibt_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .va(va), .asid(asid),
      .base(base), .mask(mask), .busy(busy), .done(done), .hit(hit),
      .fault(fault), .fault_num(fault_num), .target(target),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   // memory model: two-cycle read latency, checks request order and address
   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
         if (mem_addr !== (exp_set | 52'((nreads - rd_base) * 16))) addr_bad <= 1'b1;
         if (lat != 0) addr_bad <= 1'b1;
         paddr  <= mem_addr;
         nreads <= nreads + 1;
         lat    <= 2;
      end else if (lat != 0) begin
         lat <= lat - 1;
         if (lat == 1) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= tbl[paddr[6:4]];
         end
      end
   end

   function automatic logic [127:0] mk(logic [31:0] t, logic en, logic [6:0] rsv,
                                       logic [23:0] a, logic [63:0] v);
      return {t, en, rsv, a, v};
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // fill all ways with enabled entries that differ from v in the address
   task automatic fill_decoys(logic [63:0] v, logic [23:0] a);
      for (int w = 0; w < 8; w++)
         tbl[w] = mk(32'hDEC0_0000 + w, 1'b1, 7'd0, a, v ^ 64'(w + 1) << 8);
   endtask

   task automatic lookup(string req, logic [63:0] v, logic [23:0] a, logic [51:0] b,
                         logic [51:0] m, bit exp_hit, logic [31:0] exp_tgt, int exp_reads);
      bit seen = 0;
      @(negedge clk);
      exp_set  = (b | (v[55:4] & m)) & ~52'h7F;
      rd_base  = nreads;
      addr_bad = 0;
      va = v; asid = a; base = b; mask = m; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check({req, " busy after start"}, 64'(busy), 64'd1);
      for (int i = 0; i < 200 && !seen; i++) begin
         if (done) seen = 1;
         else @(negedge clk);
      end
      check({req, " done seen"}, 64'(seen), 64'd1);
      check({req, " hit"}, 64'(hit), 64'(exp_hit));
      check({req, " fault"}, 64'(fault), 64'(!exp_hit));
      check({req, " target"}, 64'(target), exp_hit ? 64'(exp_tgt) : 64'd0);
      check({req, " fault_num"}, 64'(fault_num), exp_hit ? 64'd0 : 64'd16);
      check({req, " busy in done"}, 64'(busy), 64'd1);
      @(negedge clk);
      check({req, " reads"}, 64'(nreads - rd_base), 64'(exp_reads));
      check({req, " R3 address order"}, 64'(addr_bad), 64'd0);
      check({req, " R8 idle after done"}, 64'(busy), 64'd0);
      check({req, " R9 quiet"}, 64'({done, hit, fault, target, fault_num}), 64'd0);
   endtask

   initial begin
      #(5 * 150000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] v;
      logic [23:0] a;
      for (int w = 0; w < 8; w++) tbl[w] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 busy", 64'(busy), 64'd0);
      check("R1 done", 64'(done), 64'd0);
      check("R1 mem_req", 64'(mem_req), 64'd0);
      check("R1 outputs", 64'({hit, fault, target, fault_num}), 64'd0);
      rst_n = 1'b1;

      // R6 R4: a qualifying entry in each way
      for (int w = 0; w < 8; w++) begin
         v = 64'hFEDC_BA98_7654_3210 + 64'(w * 4096);
         a = 24'h00A5_00 + 24'(w);
         fill_decoys(v, a);
         tbl[w] = mk(32'h7000_0000 + 32'(w * 17), 1'b1, 7'd0, a, v);
         lookup("R6 sweep", v, a, 52'hA_0000_0000_0000, 52'((64'd1 << (w + 4)) - 1),
                1'b1, 32'h7000_0000 + 32'(w * 17), w + 1);
      end

      // R7: nothing qualifies
      v = 64'h0123_4567_89AB_CDEF; a = 24'h111111;
      fill_decoys(v, a);
      lookup("R7 miss", v, a, 52'h1_2340_0000_0000, 52'hFFFF, 1'b0, 32'd0, 8);

      // R6: two qualifying ways, lowest wins
      fill_decoys(v, a);
      tbl[2] = mk(32'hAAAA_0002, 1'b1, 7'd0, a, v);
      tbl[5] = mk(32'hAAAA_0005, 1'b1, 7'd0, a, v);
      lookup("R6 lowest way", v, a, 52'h0, 52'h3FF, 1'b1, 32'hAAAA_0002, 3);

      // R5: reserved bits set at way 1, true hit at way 6
      fill_decoys(v, a);
      tbl[1] = mk(32'hBAD0_0001, 1'b1, 7'h40, a, v);
      tbl[6] = mk(32'h600D_0006, 1'b1, 7'd0, a, v);
      lookup("R5 reserved", v, a, 52'h0, 52'hFF, 1'b1, 32'h600D_0006, 7);

      // R4: enable clear at way 0, hit at way 3
      fill_decoys(v, a);
      tbl[0] = mk(32'hBAD0_0000, 1'b0, 7'd0, a, v);
      tbl[3] = mk(32'h600D_0003, 1'b1, 7'd0, a, v);
      lookup("R4 disabled", v, a, 52'h0, 52'hFF, 1'b1, 32'h600D_0003, 4);

      // R4: asid off by one everywhere
      for (int w = 0; w < 8; w++) tbl[w] = mk(32'hBAD0_0010, 1'b1, 7'd0, a + 24'd1, v);
      lookup("R4 asid", v, a, 52'h0, 52'hFF, 1'b0, 32'd0, 8);

      // R4: address differs in bit 63 everywhere
      for (int w = 0; w < 8; w++) tbl[w] = mk(32'hBAD0_0020, 1'b1, 7'd0, a, v ^ (64'd1 << 63));
      lookup("R4 va", v, a, 52'h0, 52'hFF, 1'b0, 32'd0, 8);

      // R2: mask width sweep, every request address checked by the memory model
      for (int k = 0; k <= 20; k++) begin
         v = 64'h5A5A_C3C3_9696_F0F0 ^ 64'(k * 64'h1111);
         fill_decoys(v, a);
         lookup("R2 set address", v, a, 52'h8_0000_0000_0000, 52'((64'd1 << k) - 1),
                1'b0, 32'd0, 8);
      end

      // R8: a second start while busy is ignored
      v = 64'h0000_1111_2222_3330; a = 24'h00BEEF;
      fill_decoys(v, a);
      tbl[0] = mk(32'hBAD0_0099, 1'b1, 7'd0, a, 64'h9999_0000_0000_0000);
      tbl[4] = mk(32'h600D_0004, 1'b1, 7'd0, a, v);
      @(negedge clk);
      exp_set = (52'h0 | (v[55:4] & 52'hFFF)) & ~52'h7F;
      rd_base = nreads; addr_bad = 0;
      va = v; asid = a; base = '0; mask = 52'hFFF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      va = 64'h9999_0000_0000_0000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 200 && !done; i++) @(negedge clk);
      check("R8 ignored start hit", 64'(hit), 64'd1);
      check("R8 ignored start target", 64'(target), 64'h600D_0004);
      repeat (20) @(negedge clk);
      check("R8 ignored start reads", 64'(nreads - rd_base), 64'd5);
      check("R8 ignored start idle", 64'(busy), 64'd0);
      check("R3 ignored start order", 64'(addr_bad), 64'd0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule